// File: doc/BRIEF.md
# Control Store Byte-Lane Loader

This block holds a 48-bit-wide microinstruction store and fills it one byte at a time from an I/O-processor write port. A small file of task program counters sits beside the store. One fixed entry of that file, entry 6, supplies the word address for every byte write. The loader does not take an address with each byte.

Each byte write carries a lane index and a data byte. The writer has already inverted the byte, and the loader stores it exactly as it arrives. The loader reads the addressed word, replaces only the bits that belong to the selected lane, and writes the word back in the same clock.

Lanes 0 to 2 each fill one whole byte of the word. Lanes 3 to 5 each carry two nibbles. The upper nibble is a function-select field. The lower nibble is one slice of a 12-bit next-address field. The two nibbles of one lane go to bit positions that are far apart in the word. A lane index of 6 or 7 leaves the store untouched and raises an error pulse. A combinational read port lets the store be inspected.

Top module: `ucode_lane_loader`

## Requirements
- R1: After reset, every store word and every task PC entry is zero, and `err_pulse` is low.
- R2: When `tpc_we` is high, task PC entry `tpc_sel` takes `tpc_wdata` at the clock edge.
- R3: A byte write always targets the word addressed by task PC entry 6. No other entry influences the target.
- R4: Lane 0 replaces bits 47:40, lane 1 replaces bits 39:32, and lane 2 replaces bits 31:24, each with the data byte unchanged.
- R5: Lane 3 places data bits 7:4 at word bits 19:16 and data bits 3:0 at word bits 11:8.
- R6: Lane 4 places data bits 7:4 at word bits 23:20 and data bits 3:0 at word bits 7:4.
- R7: Lane 5 places data bits 7:4 at word bits 15:12 and data bits 3:0 at word bits 3:0.
- R8: The data byte is stored without inversion, and every bit outside the selected lane keeps its prior value.
- R9: A write with lane index 6 or 7 leaves the store unchanged. It drives `err_pulse` high for exactly the following cycle.
- R10: `err_pulse` is low in any cycle that does not follow an illegal-lane write.
- R11: If a task PC entry 6 update and a byte write occur in the same cycle, the byte lands at the old entry-6 address.
- R12: `rd_data` shows `store[rd_addr]` combinationally, so a merged word is visible in the cycle after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tpc_we | input | 1 | Task PC write enable |
| tpc_sel | input | TPC_SEL_W | Task PC entry to write |
| tpc_wdata | input | ADDR_W | Value for the task PC entry |
| lane_we | input | 1 | Byte write strobe |
| lane_idx | input | 3 | Lane index, 0 to 5 legal |
| lane_data | input | 8 | Pre-inverted data byte |
| err_pulse | output | 1 | One-cycle flag after an illegal lane index |
| rd_addr | input | ADDR_W | Inspection read address |
| rd_data | output | 48 | Word at `rd_addr` |

## Verification
The bench builds the loader with ADDR_W=4 (16 words) and the default 3-bit task PC selector (8 entries). With only 16 words, the top address 15 is easy to reach, and the bench checks that a write there does not alias onto a low word. The full 8-entry PC file lets the bench load a decoy address into entries other than 6 and confirm that each byte still lands at the entry-6 address. A cumulative vector sequence builds one word lane by lane. It mixes legal and illegal indices, and it rewrites split lanes so that the bench can see neighbouring nibbles survive each merge.

// File: rtl/ucode_lane_loader.sv
module ucode_lane_loader #(
  parameter int ADDR_W    = 6,
  parameter int TPC_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tpc_we,
  input  logic [TPC_SEL_W-1:0] tpc_sel,
  input  logic [ADDR_W-1:0]    tpc_wdata,
  input  logic                 lane_we,
  input  logic [2:0]           lane_idx,
  input  logic [7:0]           lane_data,
  output logic                 err_pulse,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [47:0]          rd_data
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int NUM_TPC  = 1 << TPC_SEL_W;
  localparam int LOAD_TPC = 6;
  localparam int LANES    = 6;

  logic [47:0]       store [DEPTH];
  logic [ADDR_W-1:0] tpc   [NUM_TPC];
  logic [ADDR_W-1:0] cur_addr;
  logic              legal;
  logic [47:0]       merged;

  assign cur_addr = tpc[LOAD_TPC];
  assign legal    = int'(lane_idx) < LANES;
  assign rd_data  = store[rd_addr];

  function automatic logic [47:0] merge_lane(input logic [47:0] w, input logic [2:0] idx,
                                             input logic [7:0] d);
    logic [47:0] r;
    r = w;
    case (idx)
      3'd0: r[47:40] = d;
      3'd1: r[39:32] = d;
      3'd2: r[31:24] = d;
      3'd3: begin r[19:16] = d[7:4]; r[11:8] = d[3:0]; end
      3'd4: begin r[23:20] = d[7:4]; r[7:4]  = d[3:0]; end
      3'd5: begin r[15:12] = d[7:4]; r[3:0]  = d[3:0]; end
      default: r = w;
    endcase
    return r;
  endfunction

  assign merged = merge_lane(store[cur_addr], lane_idx, lane_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      for (int j = 0; j < NUM_TPC; j++) tpc[j] <= '0;
      err_pulse <= 1'b0;
    end else begin
      if (tpc_we) tpc[tpc_sel] <= tpc_wdata;
      if (lane_we && legal) store[cur_addr] <= merged;
      err_pulse <= lane_we && !legal;
    end
  end

  // R9
  illegal_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && !legal) |=> (store[$past(cur_addr)] == $past(store[cur_addr])));

  // R9
  illegal_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && !legal) |=> err_pulse);

  // R10
  legal_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_we && !legal) |=> !err_pulse);

  // R4
  lane0_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && lane_idx == 3'd0) |=> (store[$past(cur_addr)][47:40] == $past(lane_data)));

  // R8
  lane0_rest_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && lane_idx == 3'd0) |=> (store[$past(cur_addr)][39:0] == $past(store[cur_addr][39:0])));

  // R5
  lane3_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && lane_idx == 3'd3) |=>
      ({store[$past(cur_addr)][19:16], store[$past(cur_addr)][11:8]} == $past(lane_data)));

  // R7
  lane5_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we && lane_idx == 3'd5) |=>
      ({store[$past(cur_addr)][15:12], store[$past(cur_addr)][3:0]} == $past(lane_data)));

  // R2
  tpc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpc_we |=> (tpc[$past(tpc_sel)] == $past(tpc_wdata)));
endmodule

// File: tb/ucode_lane_loader_tb.sv
module ucode_lane_loader_tb_top;
  localparam int AW = 4;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tpc_we;
  logic [SW-1:0] tpc_sel;
  logic [AW-1:0] tpc_wdata;
  logic          lane_we;
  logic [2:0]    lane_idx;
  logic [7:0]    lane_data;
  logic          err_pulse;
  logic [AW-1:0] rd_addr;
  logic [47:0]   rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucode_lane_loader #(.ADDR_W(AW), .TPC_SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tpc_we(tpc_we), .tpc_sel(tpc_sel), .tpc_wdata(tpc_wdata),
    .lane_we(lane_we), .lane_idx(lane_idx), .lane_data(lane_data), .err_pulse(err_pulse),
    .rd_addr(rd_addr), .rd_data(rd_data));

  // {lane, data, expected err, expected word} applied in order to one word
  localparam int NV = 10;
  localparam logic [59:0] VEC [NV] = '{
    {3'd0, 8'hA5, 1'b0, 48'hA53C_F079_16EB & 48'hA500_0000_0000},
    {3'd1, 8'h3C, 1'b0, 48'hA53C_0000_0000},
    {3'd2, 8'hF0, 1'b0, 48'hA53C_F000_0000},
    {3'd3, 8'h96, 1'b0, 48'hA53C_F009_0600},
    {3'd4, 8'h7E, 1'b0, 48'hA53C_F079_06E0},
    {3'd5, 8'h1B, 1'b0, 48'hA53C_F079_16EB},
    {3'd6, 8'hFF, 1'b1, 48'hA53C_F079_16EB},
    {3'd3, 8'h00, 1'b0, 48'hA53C_F070_10EB},
    {3'd7, 8'h12, 1'b1, 48'hA53C_F070_10EB},
    {3'd0, 8'h00, 1'b0, 48'h003C_F070_10EB}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_tpc(input int sel, input int val);
    @(negedge clk);
    tpc_we = 1'b1; tpc_sel = SW'(sel); tpc_wdata = AW'(val);
    @(negedge clk);
    tpc_we = 1'b0;
  endtask

  task automatic put_lane(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    lane_we = 1'b1; lane_idx = idx; lane_data = d;
    @(negedge clk);
    lane_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tpc_we = 1'b0; tpc_sel = '0; tpc_wdata = '0;
    lane_we = 1'b0; lane_idx = '0; lane_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a += 5) begin
      rd_addr = AW'(a); #1;
      check("R1 word zero", rd_data, 48'h0);
    end
    check("R1 err low", {47'h0, err_pulse}, 48'h0);

    // R2/R3: decoy in entry 2, target in entry 6
    set_tpc(2, 9);
    set_tpc(6, 5);
    rd_addr = AW'(5);
    for (int v = 0; v < NV; v++) begin
      logic [59:0] e;
      e = VEC[v];
      put_lane(e[59:57], e[56:49]);
      check($sformatf("R4-7/R8 vec%0d word", v), rd_data, e[47:0]);
      check($sformatf("R9/R10 vec%0d err", v), {47'h0, err_pulse}, {47'h0, e[48]});
      @(negedge clk);
      check("R9 err one cycle", {47'h0, err_pulse}, 48'h0);
    end
    rd_addr = AW'(9); #1;
    check("R3 decoy address untouched", rd_data, 48'h0);

    // R11: entry 6 update in same cycle as a byte write
    @(negedge clk);
    tpc_we = 1'b1; tpc_sel = SW'(6); tpc_wdata = AW'(15);
    lane_we = 1'b1; lane_idx = 3'd2; lane_data = 8'h5A;
    @(negedge clk);
    tpc_we = 1'b0; lane_we = 1'b0;
    rd_addr = AW'(5); #1;
    check("R11 old address written", rd_data, 48'h003C_5A70_10EB);
    rd_addr = AW'(15); #1;
    check("R11 new address untouched", rd_data, 48'h0);

    // R12/R6: top address, visible next cycle, no alias to word 0
    put_lane(3'd4, 8'hC3);
    check("R12 R6 top word", rd_data, 48'h0000_00C0_0030);
    rd_addr = AW'(0); #1;
    check("R3 no alias at word 0", rd_data, 48'h0);

    // R5/R7 on a fresh word: other split nibbles stay
    put_lane(3'd5, 8'hE1);
    rd_addr = AW'(15); #1;
    check("R7 split lane", rd_data, 48'h0000_00C0_E031);
    put_lane(3'd3, 8'h48);
    check("R5 split lane", rd_data, 48'h0000_00C4_E831);

    // R9 illegal on this word, no store change
    put_lane(3'd7, 8'h00);
    check("R9 illegal keeps word", rd_data, 48'h0000_00C4_E831);
    check("R9 err raised", {47'h0, err_pulse}, 48'h1);
    finish_run();
  end
endmodule